// File: doc/BRIEF.md
# Floppy Controller Host Register File

This block is the byte-wide register set that a host processor sees when it talks to a PC-compatible floppy disk controller. It decodes a three-bit I/O offset for reads and writes. It holds the digital output register, the data-rate select register, the configuration control register and the tape register. It also returns two status views and the digital input view. The command sequencer, the data FIFO, the data separator and the DMA engine sit outside the block. Their status reaches it as plain inputs, and the block passes their data bytes through at the right offsets.

The status layouts follow a compatibility mode input: 0 is AT, 1 is PS/2, 2 is Model-30, and 3 behaves as AT. The block drives active-low drive-select and motor outputs, a density code and a precompensation code, and it gates the DMA and interrupt handshakes. Edge-sensitive disk status is held in toggle bits and read-cleared latches. The serial read-data and write-data pins pass through a two-flop synchronizer before their edges are detected.

A small controller produces the software reset. Its states are ST_HOLD (reset held by the output register), ST_RUN (normal operation) and ST_PULSE (a single-cycle reset issued from the rate register). The transitions are:
- ST_HOLD→ST_RUN when the output register is written with bit 2 set.
- ST_RUN→ST_HOLD when the output register is written with bit 2 clear.
- ST_RUN→ST_PULSE when the rate register is written with bit 7 set.
- ST_PULSE→ST_RUN after one cycle if bit 2 of the output register is 1, and ST_PULSE→ST_HOLD if it is 0.

Hardware reset enters ST_HOLD.

Top module: `flop_host_regs`

## Requirements
- R1: After hardware reset the output register is 00h, so `soft_rst` is 1 and `ds_n`/`mtr_n` are 2'b11. `density` is 2'b10 and `precomp` is 3'b000, because the rate register loads 02h. The tape register reads 0.
- R2: In AT mode (mode 0 or 3), reads of offsets 0 and 1 drive `rdata_oe` = 00h.
- R3: Status A at offset 0 in PS/2 mode is {intr_out, 1, step, trk0_n, hdsel, index_n, wprot_n, head_dir}, from bit 7 down to bit 0. In Model-30 mode it is {intr_out, drq_in, step latch, ~trk0_n, ~hdsel, ~index_n, ~wprot_n, ~head_dir}.
- R4: Status B at offset 1 in PS/2 mode is {1, 1, output-register bit 0, write-data toggle, read-data toggle, wgate, output-register bit 5, output-register bit 4}. Each rising (inactive) edge of `rddat_n` or `wrdat_n` flips its toggle.
- R5: Status B in Model-30 mode is {1, ds_n[1], ds_n[0], write-data latch, read-data latch, write-gate latch, 1, 1}. The latches are set by the inactive edge of the data pins and by the rising edge of `wgate`, and a step latch is set by the rising edge of `step`. A read of offset 7 in Model-30 mode clears all four latches. Software reset also clears the step latch.
- R6: Writing offset 2 with bit 2 = 0 holds `soft_rst` high until a write with bit 2 = 1. During the hold the other output-register bits, the rate and the precompensation keep their values.
- R7: Writing offset 4 with bit 7 = 1 raises `soft_rst` for exactly one cycle. The bit does not stay set.
- R8: `density` takes bits 1:0 of whichever write was most recent: offset 4 (rate select) or offset 7 (configuration control). Offset 4 bits 4:2 set `precomp`.
- R9: When the output register's bit 3 is 0 in AT or Model-30 mode, these outputs are forced inactive: `drq_oe`=0, `drq_out`=0, `dack_n_out`=1, `tc_out`=0, `intr_out`=0. In PS/2 mode, and whenever bit 3 is 1, they pass the inputs through.
- R10: Drive select in the output register is bits 1:0 and the motors are bits 4 and 5. `ds_n[0]` is low only when select = 0 and bit 4 = 1, and `ds_n[1]` is low only when select = 1 and bit 5 = 1. `mtr_n[i]` is the inverse of the motor bit. `swap_drives` exchanges the two pins of each pair.
- R11: Offset 7 reads drive only bit 7. That bit is `force_dskchg_val` when `force_dskchg_en` is 1, and ~`dskchg_n` otherwise.
- R12: The tape register at offset 3 stores bits 1:0. Reads drive `rdata_oe` = 03h.
- R13: Offset 2 reads back the output register. Offset 4 reads return `msr_in`, offset 5 reads return `fifo_in`, and offset 6 drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Hardware reset, active low |
| mode | input | 2 | Compatibility mode: 0 AT, 1 PS/2, 2 Model-30 |
| swap_drives | input | 1 | Exchange drive 0 and drive 1 pins |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 8 | Per-bit read-data drive enable |
| fifo_we | output | 1 | Write strobe toward the data FIFO (offset 5) |
| msr_in | input | 8 | Main status byte from the sequencer |
| fifo_in | input | 8 | Data byte from the FIFO |
| head_dir | input | 1 | Step direction, 1 = inward |
| step | input | 1 | Step pulse from the sequencer |
| wgate | input | 1 | Write gate from the sequencer |
| hdsel | input | 1 | Head select, 1 = side 1 |
| wprot_n | input | 1 | Write-protect pin, active low |
| index_n | input | 1 | Index pin, active low |
| trk0_n | input | 1 | Track-0 pin, active low |
| dskchg_n | input | 1 | Disk-change pin, active low |
| force_dskchg_en | input | 1 | Use forced disk-change value |
| force_dskchg_val | input | 1 | Forced disk-change value |
| rddat_n | input | 1 | Raw read-data pin, active low, asynchronous |
| wrdat_n | input | 1 | Write-data pin, active low, asynchronous |
| intr_in | input | 1 | Interrupt from the sequencer |
| drq_in | input | 1 | DMA request from the DMA engine |
| dack_n_in | input | 1 | DMA acknowledge from the host, active low |
| tc_in | input | 1 | Terminal count from the host |
| intr_out | output | 1 | Gated interrupt |
| drq_out | output | 1 | Gated DMA request |
| drq_oe | output | 1 | DMA request drive enable |
| dack_n_out | output | 1 | Gated DMA acknowledge |
| tc_out | output | 1 | Gated terminal count |
| soft_rst | output | 1 | Software reset to the controller core |
| ds_n | output | 2 | Drive selects, active low |
| mtr_n | output | 2 | Motor enables, active low |
| density | output | 2 | Effective data-rate / density code |
| precomp | output | 3 | Write precompensation code |

## Verification
The hardest state to reach is a Model-30 latch that has been set by an asynchronous data-pin edge and has not yet been cleared. The pin must first cross the synchronizer and then produce a rising edge, and only a read of the digital input register in the same mode clears the latch. The stimulus holds a pin low for two cycles and releases it, then waits past the synchronizer depth. It reads status B in PS/2 mode to see the toggle and in Model-30 mode to see the latch. It then reads offset 7 in Model-30 mode and reads status B again to confirm the clear. The step latch gets the same treatment, except that a software-reset hold through the output register clears it.

// File: rtl/fdcr_pkg.sv
package fdcr_pkg;
    localparam int          DW        = 8;
    localparam int          AW        = 3;
    localparam logic [1:0]  MODE_AT   = 2'd0;
    localparam logic [1:0]  MODE_PS2  = 2'd1;
    localparam logic [1:0]  MODE_M30  = 2'd2;
    localparam logic [AW-1:0] OFS_STA  = 3'd0;
    localparam logic [AW-1:0] OFS_STB  = 3'd1;
    localparam logic [AW-1:0] OFS_DOUT = 3'd2;
    localparam logic [AW-1:0] OFS_TAPE = 3'd3;
    localparam logic [AW-1:0] OFS_RATE = 3'd4;
    localparam logic [AW-1:0] OFS_DATA = 3'd5;
    localparam logic [AW-1:0] OFS_DIN  = 3'd7;
    localparam logic [1:0]  RATE_RST  = 2'b10;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } rst_state_e;
endpackage

// File: rtl/fdcr_rst_ctl.sv
module fdcr_rst_ctl
    import fdcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dout_wr,
    input  logic dout_nrst_bit,
    input  logic dout_nrst_q,
    input  logic rate_wr,
    input  logic rate_rst_bit,
    output logic soft_rst
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (dout_wr && dout_nrst_bit) state_d = ST_RUN;
            ST_RUN: begin
                if (rate_wr && rate_rst_bit)         state_d = ST_PULSE;
                else if (dout_wr && !dout_nrst_bit)  state_d = ST_HOLD;
            end
            ST_PULSE: state_d = dout_nrst_q ? ST_RUN : ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  soft_rst = 1'b0;
            default: soft_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/fdcr_edge_stat.sv
module fdcr_edge_stat #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pin_n,
    input  logic       step,
    input  logic       wgate,
    input  logic       sw_rst,
    input  logic       rd_clr,
    output logic [1:0] tog,
    output logic [1:0] pin_lat,
    output logic       wg_lat,
    output logic       step_lat
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [1:0] pin_rise;
    logic       step_q, wgate_q;

    for (genvar g = 0; g < 2; g++) begin : g_pin
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '1;
                prev_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n[g]};
                prev_q <= sync_q[LAST];
            end
        end
        assign pin_rise[g] = sync_q[LAST] & ~prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tog[g]     <= 1'b0;
                pin_lat[g] <= 1'b0;
            end else begin
                if (pin_rise[g]) tog[g] <= ~tog[g];
                if (pin_rise[g])  pin_lat[g] <= 1'b1;
                else if (rd_clr)  pin_lat[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= 1'b0;
            wgate_q  <= 1'b0;
            wg_lat   <= 1'b0;
            step_lat <= 1'b0;
        end else begin
            step_q  <= step;
            wgate_q <= wgate;
            if (wgate && !wgate_q) wg_lat <= 1'b1;
            else if (rd_clr)       wg_lat <= 1'b0;
            if (sw_rst)                   step_lat <= 1'b0;
            else if (step && !step_q)     step_lat <= 1'b1;
            else if (rd_clr)              step_lat <= 1'b0;
        end
    end
endmodule

// File: rtl/fdcr_drive_dec.sv
module fdcr_drive_dec #(
    parameter int NUM_DRV = 2
) (
    input  logic [1:0]         sel,
    input  logic [NUM_DRV-1:0] mot,
    input  logic               swap,
    output logic [NUM_DRV-1:0] ds_n,
    output logic [NUM_DRV-1:0] mtr_n
);
    for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
        logic lg;
        assign lg       = (i != 0) ^ swap;
        assign ds_n[i]  = ~((sel == {1'b0, lg}) && mot[lg]);
        assign mtr_n[i] = ~mot[lg];
    end
endmodule

// File: rtl/flop_host_regs.sv
module flop_host_regs
    import fdcr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       swap_drives,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] rdata_oe,
    output logic       fifo_we,
    input  logic [7:0] msr_in,
    input  logic [7:0] fifo_in,
    input  logic       head_dir,
    input  logic       step,
    input  logic       wgate,
    input  logic       hdsel,
    input  logic       wprot_n,
    input  logic       index_n,
    input  logic       trk0_n,
    input  logic       dskchg_n,
    input  logic       force_dskchg_en,
    input  logic       force_dskchg_val,
    input  logic       rddat_n,
    input  logic       wrdat_n,
    input  logic       intr_in,
    input  logic       drq_in,
    input  logic       dack_n_in,
    input  logic       tc_in,
    output logic       intr_out,
    output logic       drq_out,
    output logic       drq_oe,
    output logic       dack_n_out,
    output logic       tc_out,
    output logic       soft_rst,
    output logic [1:0] ds_n,
    output logic [1:0] mtr_n,
    output logic [1:0] density,
    output logic [2:0] precomp
);
    logic [DW-1:0] dout_q;
    logic [1:0]    tape_q, rate_q;
    logic [2:0]    pc_q;
    logic          is_ps2, is_m30, hs_en;
    logic          dout_wr, tape_wr, rate_wr, ccr_wr, din_clr;
    logic [1:0]    tog, pin_lat;
    logic          wg_lat, step_lat;
    logic [7:0]    sta_v, stb_v;

    assign is_ps2  = (mode == MODE_PS2);
    assign is_m30  = (mode == MODE_M30);
    assign dout_wr = wr_en && (addr == OFS_DOUT);
    assign tape_wr = wr_en && (addr == OFS_TAPE);
    assign rate_wr = wr_en && (addr == OFS_RATE);
    assign ccr_wr  = wr_en && (addr == OFS_DIN);
    assign fifo_we = wr_en && (addr == OFS_DATA);
    assign din_clr = rd_en && (addr == OFS_DIN) && is_m30;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            tape_q <= '0;
            rate_q <= RATE_RST;
            pc_q   <= '0;
        end else begin
            if (dout_wr) dout_q <= wdata;
            if (tape_wr) tape_q <= wdata[1:0];
            if (rate_wr) begin
                rate_q <= wdata[1:0];
                pc_q   <= wdata[4:2];
            end else if (ccr_wr) begin
                rate_q <= wdata[1:0];
            end
        end
    end

    fdcr_rst_ctl u_rst (
        .clk(clk), .rst_n(rst_n),
        .dout_wr(dout_wr), .dout_nrst_bit(wdata[2]), .dout_nrst_q(dout_q[2]),
        .rate_wr(rate_wr), .rate_rst_bit(wdata[7]),
        .soft_rst(soft_rst)
    );

    fdcr_edge_stat #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .pin_n({wrdat_n, rddat_n}), .step(step), .wgate(wgate),
        .sw_rst(soft_rst), .rd_clr(din_clr),
        .tog(tog), .pin_lat(pin_lat), .wg_lat(wg_lat), .step_lat(step_lat)
    );

    fdcr_drive_dec #(.NUM_DRV(2)) u_drv (
        .sel(dout_q[1:0]), .mot(dout_q[5:4]), .swap(swap_drives),
        .ds_n(ds_n), .mtr_n(mtr_n)
    );

    assign hs_en      = is_ps2 || dout_q[3];
    assign intr_out   = intr_in & hs_en;
    assign drq_out    = drq_in & hs_en;
    assign drq_oe     = hs_en;
    assign dack_n_out = dack_n_in | ~hs_en;
    assign tc_out     = tc_in & hs_en;
    assign density    = rate_q;
    assign precomp    = pc_q;

    always_comb begin
        if (is_m30) begin
            sta_v = {intr_out, drq_in, step_lat, ~trk0_n, ~hdsel, ~index_n, ~wprot_n, ~head_dir};
            stb_v = {1'b1, ds_n[1], ds_n[0], pin_lat[1], pin_lat[0], wg_lat, 2'b11};
        end else begin
            sta_v = {intr_out, 1'b1, step, trk0_n, hdsel, index_n, wprot_n, head_dir};
            stb_v = {2'b11, dout_q[0], tog[1], tog[0], wgate, dout_q[5], dout_q[4]};
        end
    end

    always_comb begin
        rdata    = '0;
        rdata_oe = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_STA:  if (is_ps2 || is_m30) begin rdata = sta_v; rdata_oe = '1; end
                OFS_STB:  if (is_ps2 || is_m30) begin rdata = stb_v; rdata_oe = '1; end
                OFS_DOUT: begin rdata = dout_q; rdata_oe = '1; end
                OFS_TAPE: begin rdata = {6'b0, tape_q}; rdata_oe = 8'h03; end
                OFS_RATE: begin rdata = msr_in; rdata_oe = '1; end
                OFS_DATA: begin rdata = fifo_in; rdata_oe = '1; end
                OFS_DIN:  begin
                    rdata    = {(force_dskchg_en ? force_dskchg_val : ~dskchg_n), 7'b0};
                    rdata_oe = 8'h80;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fdcr_checker.sv
module fdcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata_oe,
    input logic       drq_oe,
    input logic       drq_out,
    input logic       soft_rst,
    input logic [1:0] ds_n,
    input logic [1:0] density
);
    AST_AT_STATUS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[2:1] == 2'b00 && (mode == 2'd0 || mode == 2'd3)) |-> rdata_oe == 8'h00); // R2
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && !wdata[2]) |=> soft_rst); // R6
    AST_RATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4 && wdata[7]) |=> soft_rst); // R7
    AST_CCR_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7) |=> density == $past(wdata[1:0])); // R8
    AST_PS2_DRQ_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> drq_oe); // R9
    AST_DRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !drq_oe |-> !drq_out); // R9
    AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ds_n)); // R10
    AST_TAPE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd3) |-> rdata_oe == 8'h03); // R12
endmodule

bind flop_host_regs fdcr_checker u_chk (.*);

// File: tb/tb_flop_host_regs.sv
module tb_flop_host_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic [1:0] mode = 0;
    logic swap_drives = 0;
    logic [2:0] addr = 0;
    logic wr_en = 0, rd_en = 0;
    logic [7:0] wdata = 0, rdata, rdata_oe;
    logic fifo_we;
    logic [7:0] msr_in = 8'h80, fifo_in = 8'h5A;
    logic head_dir = 1, step = 0, wgate = 0, hdsel = 1, wprot_n = 0, index_n = 1, trk0_n = 0;
    logic dskchg_n = 0, force_dskchg_en = 0, force_dskchg_val = 0;
    logic rddat_n = 1, wrdat_n = 1;
    logic intr_in = 1, drq_in = 1, dack_n_in = 0, tc_in = 1;
    logic intr_out, drq_out, drq_oe, dack_n_out, tc_out, soft_rst;
    logic [1:0] ds_n, mtr_n, density;
    logic [2:0] precomp;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flop_host_regs dut (.*);

    // {req[3:0], mode[1:0], wr, addr[2:0], data[7:0], oe[7:0]}
    localparam int NV = 14;
    localparam logic [25:0] VEC [NV] = '{
        {4'd13, 2'd0, 1'b1, 3'd2, 8'h1C, 8'h00}, // R13 write output register
        {4'd13, 2'd0, 1'b0, 3'd2, 8'h1C, 8'hFF}, // R13 readback
        {4'd2,  2'd0, 1'b0, 3'd0, 8'h00, 8'h00}, // R2
        {4'd2,  2'd0, 1'b0, 3'd1, 8'h00, 8'h00}, // R2
        {4'd3,  2'd1, 1'b0, 3'd0, 8'hCD, 8'hFF}, // R3 PS/2
        {4'd3,  2'd2, 1'b0, 3'd0, 8'hD2, 8'hFF}, // R3 Model-30
        {4'd4,  2'd1, 1'b0, 3'd1, 8'hC1, 8'hFF}, // R4
        {4'd5,  2'd2, 1'b0, 3'd1, 8'hC3, 8'hFF}, // R5
        {4'd12, 2'd0, 1'b1, 3'd3, 8'hFF, 8'h00}, // R12 write
        {4'd12, 2'd0, 1'b0, 3'd3, 8'h03, 8'h03}, // R12 read
        {4'd11, 2'd0, 1'b0, 3'd7, 8'h80, 8'h80}, // R11
        {4'd13, 2'd1, 1'b0, 3'd4, 8'h80, 8'hFF}, // R13 status
        {4'd13, 2'd1, 1'b0, 3'd5, 8'h5A, 8'hFF}, // R13 data
        {4'd13, 2'd1, 1'b0, 3'd6, 8'h00, 8'h00}  // R13 empty
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] oe);
        @(negedge clk); rd_en = 1; addr = a;
        #1 d = rdata; oe = rdata_oe;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic pulse_pin(input bit wr_pin);
        @(negedge clk);
        if (wr_pin) wrdat_n = 0; else rddat_n = 0;
        repeat (2) @(negedge clk);
        if (wr_pin) wrdat_n = 1; else rddat_n = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] d, oe;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 soft_rst", {7'b0, soft_rst}, 8'h01);
        check("R1 ds_n", {6'b0, ds_n}, 8'h03);
        check("R1 mtr_n", {6'b0, mtr_n}, 8'h03);
        check("R1 density", {6'b0, density}, 8'h02);
        check("R1 precomp", {5'b0, precomp}, 8'h00);
        rd(3'd3, d, oe); check("R1 tape", d & oe, 8'h00);

        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][21:20];
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][18:16], d, oe);
                check($sformatf("R%0d oe vec %0d", VEC[i][25:22], i), oe, VEC[i][7:0]);
                check($sformatf("R%0d data vec %0d", VEC[i][25:22], i), d & oe, VEC[i][15:8] & VEC[i][7:0]);
            end
        end

        // R7 self-clearing pulse, R8 rate source
        wr(3'd4, 8'h81);
        check("R7 pulse high", {7'b0, soft_rst}, 8'h01);
        check("R8 rate from select", {6'b0, density}, 8'h01);
        @(negedge clk);
        check("R7 pulse gone", {7'b0, soft_rst}, 8'h00);
        wr(3'd7, 8'h02);
        check("R8 rate from ccr", {6'b0, density}, 8'h02);
        wr(3'd4, 8'h0F);
        check("R8 rate last select", {6'b0, density}, 8'h03);
        check("R8 precomp", {5'b0, precomp}, 8'h03);

        // R6 held reset
        wr(3'd2, 8'h18);
        repeat (3) @(negedge clk);
        check("R6 held", {7'b0, soft_rst}, 8'h01);
        check("R6 rate kept", {6'b0, density}, 8'h03);
        rd(3'd2, d, oe); check("R6 dout kept", d, 8'h18);
        wr(3'd2, 8'h1C);
        check("R6 released", {7'b0, soft_rst}, 8'h00);

        // R4 toggles in PS/2 mode
        mode = 2'd1;
        pulse_pin(0);
        rd(3'd1, d, oe); check("R4 read toggle", d, 8'hC9);
        pulse_pin(1);
        rd(3'd1, d, oe); check("R4 both toggles", d, 8'hD9);
        pulse_pin(0);
        rd(3'd1, d, oe); check("R4 read toggle back", d, 8'hD1);

        // R5 Model-30 latches and clear by digital input read
        mode = 2'd2;
        @(negedge clk); wgate = 1; @(negedge clk); wgate = 0;
        @(negedge clk); step = 1; @(negedge clk); step = 0;
        @(negedge clk);
        rd(3'd1, d, oe); check("R5 latches set", d, 8'hDF);
        rd(3'd0, d, oe); check("R5 step latch", d & 8'h20, 8'h20);
        rd(3'd7, d, oe);
        rd(3'd1, d, oe); check("R5 latches cleared", d, 8'hC3);
        rd(3'd0, d, oe); check("R5 step cleared by read", d & 8'h20, 8'h00);
        @(negedge clk); step = 1; @(negedge clk); step = 0;
        wr(3'd2, 8'h18); wr(3'd2, 8'h1C);
        rd(3'd0, d, oe); check("R5 step cleared by soft reset", d & 8'h20, 8'h00);

        // R9 handshake gating
        mode = 2'd0; wr(3'd2, 8'h14);
        check("R9 AT gated", {3'b0, drq_oe, drq_out, dack_n_out, tc_out, intr_out}, 8'h04);
        mode = 2'd2; #1;
        check("R9 M30 gated", {3'b0, drq_oe, drq_out, dack_n_out, tc_out, intr_out}, 8'h04);
        mode = 2'd1; #1;
        check("R9 PS2 open", {3'b0, drq_oe, drq_out, dack_n_out, tc_out, intr_out}, 8'h1B);

        // R10 drive decode and swap
        wr(3'd2, 8'h1C);
        check("R10 drive0", {ds_n, mtr_n}, 8'h0A);
        swap_drives = 1; #1;
        check("R10 drive0 swapped", {ds_n, mtr_n}, 8'h05);
        swap_drives = 0;
        wr(3'd2, 8'h2D);
        check("R10 drive1", {ds_n, mtr_n}, 8'h05);
        wr(3'd2, 8'h3E);
        check("R10 unsupported select", {ds_n, mtr_n}, 8'h0C);
        wr(3'd2, 8'h0C);
        check("R10 motor off", {ds_n, mtr_n}, 8'h0F);

        // R11 disk change forcing
        force_dskchg_en = 1; force_dskchg_val = 0;
        rd(3'd7, d, oe); check("R11 forced", d & oe, 8'h00);
        force_dskchg_val = 1;
        rd(3'd7, d, oe); check("R11 forced one", d & oe, 8'h80);
        force_dskchg_en = 0; dskchg_n = 1;
        rd(3'd7, d, oe); check("R11 pin", d & oe, 8'h00);

        finish_run();
    end
endmodule